// File: doc/BRIEF.md
# Transmit Frame Streamer

This block sends one frame out of a shared packet buffer each time software raises a transmit request. Software fills the buffer through a byte write port and programs a 13-bit start pointer and a 13-bit end pointer through a small byte-wide register port. It then sets the request flag in the control register. The streamer skips the per-packet control byte at the start address, reads each payload byte up to and including the end address, and presents the bytes on a valid/ready/last byte stream. When the frame is finished it drops the request flag by itself. If the pointers describe no payload, it sends nothing and still drops the flag.

The buffer has one read port, shared by two users. The host side, which is the SPI command decoder in the surrounding design, has a direct read path with fixed priority. The streamer takes the read cycles that the host leaves free. The host sees its read data one cycle after each read strobe. Frame assembly details are left to a later stage: there is no preamble, CRC, padding or collision handling.

Top module: `tx_streamer`

## Requirements
- R1: After synchronous reset, ctrl_q reads 0x00 and tx_valid and buf_rd_valid are low.
- R2: The control register sits at register address 0x1F and is reached whatever the bank is. reg_op selects the update: 0 writes the byte, 1 ORs it in, 2 clears the bits that are 1 in the data, and 3 does nothing. Bit 3 is the transmit request, and making it 1 by any of these operations starts a frame.
- R3: Pointer bytes are written only while ctrl_q[1:0] is 0. The start pointer low byte is at 0x04 and its high byte at 0x05. The end pointer low byte is at 0x06 and its high byte at 0x07. Each high byte keeps only its low 5 bits, so both pointers are 13 bits wide. Writes to any other banked address have no effect.
- R4: With first = start + 1, and only when end > first, the bytes at buffer addresses first through end leave on tx_data in ascending address order. tx_last is high on the final byte only.
- R5: When end <= first, including start = 0x1FFF, no byte is presented and bit 3 of ctrl_q is back at 0 within two cycles.
- R6: Bit 3 of ctrl_q stays 1 until the final byte is accepted and reads 0 in the cycle after. The other control bits are not changed by this.
- R7: While a frame is streaming, writes that would change bit 3 have no effect, and no second frame starts once the current one ends.
- R8: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R9: A host read (buf_rd_en) always wins the buffer read port. buf_rd_valid rises one cycle later together with the byte stored at that address. Buffer writes are accepted in any cycle. Buffer addresses use their low MEM_AW bits.
- R10: The pointers are captured when a frame starts. Pointer writes made during the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register access strobe |
| reg_op | input | 2 | Register update: 0 write, 1 set bits, 2 clear bits, 3 none |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register data |
| ctrl_q | output | 8 | Control register contents; bit 3 is the transmit request |
| buf_wr_en | input | 1 | Buffer write strobe |
| buf_wr_addr | input | PTR_W | Buffer write address |
| buf_wr_data | input | 8 | Buffer write byte |
| buf_rd_en | input | 1 | Host buffer read strobe |
| buf_rd_addr | input | PTR_W | Host buffer read address |
| buf_rd_valid | output | 1 | Host read data valid, one cycle after buf_rd_en |
| buf_rd_data | output | 8 | Host read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench builds the block with PTR_W = 13 and MEM_AW = 8. With these values a 256-byte buffer is aliased by the full 13-bit pointer space. Random start pointers can therefore land anywhere, including 0x1FFF, where the first payload address overflows past every possible end pointer. The bench model stays a 256-entry array. High pointer bytes carrying junk in bits 7:5 check the masking, and random tx_ready duty and random host reads push the fetch pipeline through stalls and lost read cycles.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } reg_op_e;

  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fetch_st_e;

  // start lo, start hi, end lo, end hi follow this base in bank 0
  localparam logic [4:0] ADR_PTR_BASE = 5'h04;
  localparam logic [4:0] ADR_COMMON   = 5'h1B;
  localparam logic [4:0] ADR_CTRL     = 5'h1F;
  localparam int         REQ_BIT      = 3;
  localparam int         NUM_PTR_B    = 4;

  function automatic logic [7:0] merge_byte(reg_op_e op, logic [7:0] cur, logic [7:0] d);
    case (op)
      OP_WRITE: merge_byte = d;
      OP_SET:   merge_byte = cur | d;
      OP_CLEAR: merge_byte = cur & ~d;
      default:  merge_byte = cur;
    endcase
  endfunction

endpackage

// File: rtl/txs_regs.sv
module txs_regs
  import txs_pkg::*;
#(
  parameter int PTR_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       op,
  input  logic [4:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             busy,
  input  logic             done,
  output logic [7:0]       ctrl_q,
  output logic [PTR_W-1:0] tx_start,
  output logic [PTR_W-1:0] tx_end
);
  localparam int HI_W = PTR_W - 8;

  reg_op_e op_e;
  logic    bank0_hit;
  logic [7:0] ctrl_d;

  assign op_e      = reg_op_e'(op);
  assign bank0_hit = wr_en && (addr < ADR_COMMON) && (ctrl_q[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_PTR_B; i++) begin : g_ptr
    localparam int W = (i % 2 == 1) ? HI_W : 8;
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (bank0_hit && addr == ADR_PTR_BASE + 5'(i)) begin
        case (op_e)
          OP_WRITE: q <= wdata[W-1:0];
          OP_SET:   q <= q | wdata[W-1:0];
          OP_CLEAR: q <= q & ~wdata[W-1:0];
          default:  q <= q;
        endcase
      end
    end
  end

  assign tx_start = {g_ptr[1].q, g_ptr[0].q};
  assign tx_end   = {g_ptr[3].q, g_ptr[2].q};

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && addr == ADR_CTRL) ctrl_d = merge_byte(op_e, ctrl_q, wdata);
    if (busy) ctrl_d[REQ_BIT] = ctrl_q[REQ_BIT];
    if (done) ctrl_d[REQ_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  // R7: a running frame always sees its request flag set
  a_r7_req_kept_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> ctrl_q[REQ_BIT]);

  // R6: completion drops the request on the next cycle
  a_r6_req_drop_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !ctrl_q[REQ_BIT]);

endmodule

// File: rtl/txs_bufmem.sv
module txs_bufmem #(
  parameter int PTR_W  = 13,
  parameter int MEM_AW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             host_rd_en,
  input  logic [PTR_W-1:0] host_rd_addr,
  output logic             host_rd_valid,
  input  logic             strm_req,
  input  logic [PTR_W-1:0] strm_addr,
  output logic             strm_gnt,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0]        mem [DEPTH];
  logic [MEM_AW-1:0] wr_idx;
  logic [MEM_AW-1:0] rd_idx;
  logic              rd_any;

  assign wr_idx   = MEM_AW'(wr_addr);
  assign rd_idx   = host_rd_en ? MEM_AW'(host_rd_addr) : MEM_AW'(strm_addr);
  assign strm_gnt = strm_req && !host_rd_en;
  assign rd_any   = host_rd_en || strm_req;

  always_ff @(posedge clk) begin
    if (wr_en)  mem[wr_idx] <= wr_data;
    if (rd_any) rd_data     <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rd_valid <= 1'b0;
    else     host_rd_valid <= host_rd_en;
  end

  // R9: the host path never loses its read slot to the streamer
  a_r9_host_wins: assert property (@(posedge clk) disable iff (rst)
    host_rd_en |=> host_rd_valid);

endmodule

// File: rtl/txs_fetch.sv
module txs_fetch
  import txs_pkg::*;
#(
  parameter int PTR_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [PTR_W-1:0] tx_start,
  input  logic [PTR_W-1:0] tx_end,
  output logic             rd_req,
  output logic [PTR_W-1:0] rd_addr,
  input  logic             rd_gnt,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready
);
  localparam int CW = PTR_W + 1;

  fetch_st_e     state;
  logic [CW-1:0] first_c, last_c;
  logic [CW-1:0] nxt, last_q;
  logic          go, send, more, rd_fire, accept, accept_last;
  logic          inflt, inflt_last;
  logic          out_valid, out_last;
  logic [7:0]    out_data;

  assign first_c     = {1'b0, tx_start} + CW'(1);
  assign last_c      = {1'b0, tx_end};
  assign go          = (state == FS_IDLE) && req;
  assign send        = last_c > first_c;
  assign more        = nxt <= last_q;
  assign accept      = out_valid && tx_ready;
  assign accept_last = accept && out_last;

  assign rd_req  = (state == FS_RUN) && more && !inflt && (!out_valid || tx_ready);
  assign rd_addr = PTR_W'(nxt);
  assign rd_fire = rd_req && rd_gnt;
  assign busy    = (state == FS_RUN);
  assign done    = accept_last || (go && !send);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FS_IDLE;
      nxt    <= '0;
      last_q <= '0;
    end else begin
      case (state)
        FS_IDLE: if (go && send) begin
          state  <= FS_RUN;
          nxt    <= first_c;
          last_q <= last_c;
        end
        FS_RUN: begin
          if (rd_fire)     nxt   <= nxt + CW'(1);
          if (accept_last) state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inflt      <= 1'b0;
      inflt_last <= 1'b0;
    end else begin
      inflt <= rd_fire;
      if (rd_fire) inflt_last <= (nxt == last_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (inflt) begin
      out_valid <= 1'b1;
      out_data  <= rd_data;
      out_last  <= inflt_last;
    end else if (accept) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  assign tx_valid = out_valid;
  assign tx_data  = out_data;
  assign tx_last  = out_last;

  // R8: a stalled byte keeps its value
  a_r8_hold_stream: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R4: returning read data always finds the output slot free
  a_r4_slot_free: assert property (@(posedge clk) disable iff (rst)
    inflt |-> !out_valid);

  // R4: nothing follows the final byte
  a_r4_quiet_after_last: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready && tx_last |=> !tx_valid && !busy);

  // R5: an idle streamer presents nothing
  a_r5_idle_no_output: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_valid);

endmodule

// File: rtl/tx_streamer.sv
module tx_streamer
  import txs_pkg::*;
#(
  parameter int PTR_W  = 13,
  parameter int MEM_AW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_op,
  input  logic [4:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       ctrl_q,
  input  logic             buf_wr_en,
  input  logic [PTR_W-1:0] buf_wr_addr,
  input  logic [7:0]       buf_wr_data,
  input  logic             buf_rd_en,
  input  logic [PTR_W-1:0] buf_rd_addr,
  output logic             buf_rd_valid,
  output logic [7:0]       buf_rd_data,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready
);
  logic [PTR_W-1:0] tx_start, tx_end, strm_addr;
  logic             busy, done, strm_req, strm_gnt;
  logic [7:0]       rd_data;

  txs_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .op(reg_op), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done(done),
    .ctrl_q(ctrl_q), .tx_start(tx_start), .tx_end(tx_end)
  );

  txs_bufmem #(.PTR_W(PTR_W), .MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .rst(rst),
    .wr_en(buf_wr_en), .wr_addr(buf_wr_addr), .wr_data(buf_wr_data),
    .host_rd_en(buf_rd_en), .host_rd_addr(buf_rd_addr), .host_rd_valid(buf_rd_valid),
    .strm_req(strm_req), .strm_addr(strm_addr), .strm_gnt(strm_gnt),
    .rd_data(rd_data)
  );

  txs_fetch #(.PTR_W(PTR_W)) u_fetch (
    .clk(clk), .rst(rst),
    .req(ctrl_q[REQ_BIT]), .tx_start(tx_start), .tx_end(tx_end),
    .rd_req(strm_req), .rd_addr(strm_addr), .rd_gnt(strm_gnt), .rd_data(rd_data),
    .busy(busy), .done(done),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  assign buf_rd_data = rd_data;

endmodule

// File: tb/tb_tx_streamer.sv
module tb_tx_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W      = 13;
  localparam int MEM_AW     = 8;
  localparam int DEPTH      = 1 << MEM_AW;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_op = 2'd3;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctrl_q;
  logic buf_wr_en = 1'b0;
  logic [PTR_W-1:0] buf_wr_addr = '0;
  logic [7:0] buf_wr_data = '0;
  logic buf_rd_en = 1'b0;
  logic [PTR_W-1:0] buf_rd_addr = '0;
  logic buf_rd_valid;
  logic [7:0] buf_rd_data;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;

  tx_streamer #(.PTR_W(PTR_W), .MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_op(reg_op), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
    .buf_rd_valid(buf_rd_valid), .buf_rd_data(buf_rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] op, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_op = op; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_op = 2'd3;
  endtask

  task automatic set_ptrs(input logic [7:0] slo, input logic [7:0] shi,
                          input logic [7:0] elo, input logic [7:0] ehi);
    reg_write(2'd0, 5'h04, slo);
    reg_write(2'd0, 5'h05, shi);
    reg_write(2'd0, 5'h06, elo);
    reg_write(2'd0, 5'h07, ehi);
  endtask

  task automatic mem_put(input int idx, input logic [7:0] d);
    @(negedge clk);
    buf_wr_en = 1'b1;
    buf_wr_addr = {5'($urandom), 8'(idx)};
    buf_wr_data = d;
    model[idx] = d;
    @(negedge clk);
    buf_wr_en = 1'b0;
  endtask

  // s and e are the 13-bit pointer values the design should see
  task automatic run_frame(input int s, input int e, input logic [1:0] rop,
                           input logic [7:0] rdat, input logic [7:0] exp_after,
                           input int pct, input bit host_rd, input bit poke);
    int first = s + 1;
    int last = e;
    int n = (last > first) ? (last - first + 1) : 0;
    int idx = 0;
    bit pv = 0, pr = 0, pl = 0, fin = 0, hpend = 0, seen = 0;
    logic [7:0] pd = '0;
    logic [PTR_W-1:0] ha = '0;
    int step = 0;
    reg_write(rop, 5'h1F, rdat);
    if (n == 0) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (tx_valid) seen = 1;
      end
      chk(!seen, "R5 no byte for empty frame", seen, 0);
      chk(ctrl_q == exp_after, "R5 request cleared on empty frame", ctrl_q, exp_after);
      return;
    end
    for (int it = 0; it < 4000 && !fin; it++) begin
      @(negedge clk);
      if (pv && !pr)
        chk(tx_valid && tx_data == pd && tx_last == pl, "R8 stalled byte held",
            {tx_valid, tx_last, tx_data}, {1'b1, pl, pd});
      if (hpend) begin
        chk(buf_rd_valid && buf_rd_data == model[ha[MEM_AW-1:0]], "R9 host read mid-frame",
            {buf_rd_valid, buf_rd_data}, {1'b1, model[ha[MEM_AW-1:0]]});
        hpend = 0;
      end
      buf_rd_en = 1'b0;
      if (host_rd && $urandom_range(0, 99) < 30) begin
        ha = PTR_W'($urandom);
        buf_rd_en = 1'b1; buf_rd_addr = ha; hpend = 1;
      end
      if (poke) begin
        case (step)
          0: if (idx >= 1) begin
               reg_wr_en = 1'b1; reg_op = 2'd2; reg_addr = 5'h1F; reg_wdata = 8'h08; step = 1;
             end
          1: begin
               reg_op = 2'd0; reg_addr = 5'h04; reg_wdata = 8'($urandom); step = 2;
             end
          2: begin reg_wr_en = 1'b0; reg_op = 2'd3; step = 3; end
          default: ;
        endcase
      end
      tx_ready = ($urandom_range(0, 99) < pct);
      if (tx_valid) begin
        if (idx >= n) begin
          chk(0, "R4 byte beyond frame end", idx, n - 1);
        end else begin
          chk(tx_data == model[(first + idx) & (DEPTH - 1)], "R4 payload byte",
              tx_data, model[(first + idx) & (DEPTH - 1)]);
          chk(tx_last == (idx == n - 1), "R4 last flag", tx_last, (idx == n - 1));
          chk(ctrl_q[3] == 1'b1, "R6 request held while streaming", ctrl_q[3], 1);
        end
        if (tx_ready) begin
          if (tx_last) fin = 1;
          idx++;
        end
      end
      pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last;
    end
    @(negedge clk);
    tx_ready = 1'b0; buf_rd_en = 1'b0; reg_wr_en = 1'b0; reg_op = 2'd3;
    if (hpend)
      chk(buf_rd_valid && buf_rd_data == model[ha[MEM_AW-1:0]], "R9 host read at frame end",
          {buf_rd_valid, buf_rd_data}, {1'b1, model[ha[MEM_AW-1:0]]});
    chk(fin && idx == n, "R4 byte count", idx, n);
    chk(ctrl_q == exp_after, "R6 request cleared after final byte", ctrl_q, exp_after);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (tx_valid) seen = 1;
    end
    chk(!seen, "R7 no second frame", seen, 0);
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctrl_q == 8'h00, "R1 control reset", ctrl_q, 0);
    chk(!tx_valid, "R1 stream idle at reset", tx_valid, 0);
    chk(!buf_rd_valid, "R1 no host read data at reset", buf_rd_valid, 0);

    for (int i = 0; i < DEPTH; i++) mem_put(i, 8'($urandom));

    // R9: host reads with aliased upper address bits
    for (int k = 0; k < 6; k++) begin
      logic [PTR_W-1:0] a;
      a = PTR_W'($urandom);
      @(negedge clk);
      buf_rd_en = 1'b1; buf_rd_addr = a;
      @(negedge clk);
      buf_rd_en = 1'b0;
      chk(buf_rd_valid && buf_rd_data == model[a[MEM_AW-1:0]], "R9 host read",
          {buf_rd_valid, buf_rd_data}, {1'b1, model[a[MEM_AW-1:0]]});
    end

    // R2 plain write starts a frame, R4 basic frame
    set_ptrs(8'h10, 8'h00, 8'h1F, 8'h00);
    run_frame(13'h010, 13'h01F, 2'd0, 8'h08, 8'h00, 100, 0, 0);
    // R5 end equal to first payload address
    set_ptrs(8'h30, 8'h00, 8'h31, 8'h00);
    run_frame(13'h030, 13'h031, 2'd1, 8'h08, 8'h00, 100, 0, 0);
    // R4 shortest frame: two bytes
    set_ptrs(8'h30, 8'h00, 8'h32, 8'h00);
    run_frame(13'h030, 13'h032, 2'd1, 8'h08, 8'h00, 50, 0, 0);
    // R5 end below start
    set_ptrs(8'h50, 8'h00, 8'h40, 8'h00);
    run_frame(13'h050, 13'h040, 2'd1, 8'h08, 8'h00, 100, 0, 0);
    // R5 start at top of pointer space
    set_ptrs(8'hFF, 8'h1F, 8'hFF, 8'h1F);
    run_frame(13'h1FFF, 13'h1FFF, 2'd1, 8'h08, 8'h00, 100, 0, 0);
    // R3 junk in high bits 7:5 is dropped
    set_ptrs(8'h05, 8'hE0, 8'h15, 8'hE0);
    run_frame(13'h005, 13'h015, 2'd1, 8'h08, 8'h00, 70, 1, 0);
    // R3 pointer writes ignored outside bank 0; R6 other control bits kept
    set_ptrs(8'h20, 8'h00, 8'h27, 8'h00);
    reg_write(2'd0, 5'h1F, 8'h01);
    reg_write(2'd0, 5'h04, 8'h90);
    reg_write(2'd0, 5'h06, 8'h10);
    run_frame(13'h020, 13'h027, 2'd1, 8'h08, 8'h01, 100, 0, 0);
    reg_write(2'd0, 5'h1F, 8'h00);
    // R7 and R10: clear attempt and pointer write during the frame
    set_ptrs(8'h40, 8'h00, 8'h60, 8'h00);
    run_frame(13'h040, 13'h060, 2'd1, 8'h08, 8'h00, 40, 1, 1);

    // random frames
    for (int f = 0; f < 30; f++) begin
      int s, len, e;
      s = $urandom_range(0, 8191);
      len = $urandom_range(0, 40);
      e = (s + len - 2) & 13'h1FFF;
      for (int k = 0; k < 3; k++) mem_put($urandom_range(0, DEPTH - 1), 8'($urandom));
      set_ptrs(8'(s), {3'($urandom), 5'(s >> 8)}, 8'(e), {3'($urandom), 5'(e >> 8)});
      run_frame(s, e, 2'd1, 8'h08, 8'h00, $urandom_range(30, 100), 1, (len > 10) ? 1'b1 : 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule